// File: doc/BRIEF.md
# Single-Pin Serial Word Reader

This block reads a multi-bit word from a remote parallel-to-serial register over one bidirectional pin. Three durations share the line. A long high pulse tells the remote side to capture its parallel inputs. A medium high pulse advances the remote register by one place. A short released (tri-state) window lets the remote side drive the pin, and the controller samples the current bit during that window. Driven-low gaps separate all of these, so the remote side can see every edge.

A request starts a read. The sequencer drives one load pulse and then runs `DATA_W` read-and-shift rounds. In each round it opens the read window, captures the pin on the last cycle of the window, and then drives one shift pulse. The bits are assembled MSB first. The finished word is presented with a one-cycle strobe. Every duration is a parameter in clock cycles.

The request side is a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low for the whole transaction, and a request held during that time is neither queued nor taken. The result side has no back-pressure: `word_valid` pulses for exactly one cycle, and the consumer must take `word_data` then or read it later from the holding register.

Top module: `pin_word_sequencer`

## Requirements
- R1: During and after reset, the block drives the pin low (`pin_oe`=1, `pin_out`=0). In the same state `req_ready`=1, `busy`=0 and `word_valid`=0.
- R2: An accepted request is followed by exactly one driven-high run of `LOAD_CYC` cycles, which starts on the cycle after the accepting edge.
- R3: Each transaction contains exactly `DATA_W` driven-high shift pulses, each lasting `SHIFT_CYC` cycles.
- R4: Each transaction contains exactly `DATA_W` released windows (`pin_oe`=0), each lasting `WIN_CYC` cycles. Every window comes before its shift pulse.
- R5: A driven-low gap of exactly `GAP_CYC` cycles follows the load pulse, every window and every shift pulse except the last. That gives 2*`DATA_W` gaps per transaction.
- R6: The pin is sampled on the last cycle of each window. The first window gives bit `DATA_W`-1 (MSB first), so `word_data` equals the word held by the remote register.
- R7: `word_valid` is high for exactly one cycle. It rises `LOAD_CYC + GAP_CYC + DATA_W*(WIN_CYC + 2*GAP_CYC + SHIFT_CYC)` edges after the accepting edge.
- R8: `req_ready` is low from the accepting edge until the strobe. A request asserted during that time starts nothing, and no load pulse appears after it is withdrawn.
- R9: `word_data` changes only together with `word_valid` and keeps its value until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request |
| req_ready | output | 1 | Block can accept a request |
| pin_in | input | 1 | Sampled level of the shared pin |
| pin_oe | output | 1 | Pin drive enable (0 = released) |
| pin_out | output | 1 | Level driven while enabled |
| busy | output | 1 | Transaction in progress |
| word_valid | output | 1 | One-cycle result strobe |
| word_data | output | DATA_W | Assembled word, held until the next strobe |

## Verification
The hardest case to produce from the ports is a request that arrives while a transaction is already running. It must be refused, and it must leave no trace after the strobe. The stimulus raises `req_valid` partway through some reads and drops it before the strobe. The bench then watches the pin for an idle stretch and confirms that no load pulse appears. A bench model of the remote register decodes pulse widths against its own thresholds, so wrong pulse or window lengths show up as corrupted words and as miscounted pulse runs. Directed words with alternating bits and single set bits exercise the case where a high level during the window sits next to the gaps.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOAD,
    PH_GAP,
    PH_WIN,
    PH_SHIFT
  } phase_e;
endpackage

// File: rtl/psr_phase_timer.sv
module psr_phase_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] len,
  output logic          last
);
  logic [CW-1:0] cnt;

  assign last = run && (cnt == len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run || last) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  // R5: the count never runs past the current phase length
  a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < len));
endmodule

// File: rtl/psr_bit_collector.sv
module psr_bit_collector #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         capture,
  input  logic         bit_in,
  output logic [W-1:0] word,
  output logic         full
);
  localparam int NW = $clog2(W + 1);
  logic [NW-1:0] n;

  assign full = (n == NW'(W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      n    <= '0;
    end else if (clr) begin
      word <= '0;
      n    <= '0;
    end else if (capture) begin
      word <= {word[W-2:0], bit_in};
      n    <= n + 1'b1;
    end
  end

  // R6: no more than W bits are taken per transaction
  a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !full);
endmodule

// File: rtl/pin_word_sequencer.sv
module pin_word_sequencer
  import psr_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int LOAD_CYC  = 40,
  parameter int SHIFT_CYC = 12,
  parameter int WIN_CYC   = 3,
  parameter int GAP_CYC   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              pin_in,
  output logic              pin_oe,
  output logic              pin_out,
  output logic              busy,
  output logic              word_valid,
  output logic [DATA_W-1:0] word_data
);
  localparam int CW = $clog2(LOAD_CYC + SHIFT_CYC + WIN_CYC + GAP_CYC + 1);

  phase_e        state, gap_next;
  logic [CW-1:0] phase_len;
  logic          t_last, full, capture, clr;
  logic [DATA_W-1:0] acc;

  always_comb begin
    unique case (state)
      PH_LOAD:  phase_len = CW'(LOAD_CYC);
      PH_SHIFT: phase_len = CW'(SHIFT_CYC);
      PH_WIN:   phase_len = CW'(WIN_CYC);
      default:  phase_len = CW'(GAP_CYC);
    endcase
  end

  assign busy      = (state != PH_IDLE);
  assign req_ready = !busy;
  assign pin_oe    = (state != PH_WIN);
  assign pin_out   = (state == PH_LOAD) || (state == PH_SHIFT);
  assign clr       = (state == PH_IDLE) && req_valid;
  assign capture   = (state == PH_WIN) && t_last;

  psr_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .len(phase_len), .last(t_last)
  );

  psr_bit_collector #(.W(DATA_W)) u_collect (
    .clk(clk), .rst_n(rst_n), .clr(clr), .capture(capture),
    .bit_in(pin_in), .word(acc), .full(full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PH_IDLE;
      gap_next <= PH_IDLE;
    end else begin
      unique case (state)
        PH_IDLE:  if (req_valid) state <= PH_LOAD;
        PH_LOAD:  if (t_last) begin state <= PH_GAP; gap_next <= PH_WIN; end
        PH_GAP:   if (t_last) state <= gap_next;
        PH_WIN:   if (t_last) begin state <= PH_GAP; gap_next <= PH_SHIFT; end
        PH_SHIFT: if (t_last) begin
                    state    <= PH_GAP;
                    gap_next <= full ? PH_IDLE : PH_WIN;
                  end
        default:  state <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_valid <= 1'b0;
      word_data  <= '0;
    end else begin
      word_valid <= (state == PH_GAP) && t_last && (gap_next == PH_IDLE);
      if ((state == PH_GAP) && t_last && (gap_next == PH_IDLE))
        word_data <= acc;
    end
  end

  // R2: a load phase is only entered from idle on a request
  a_r2_load_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_LOAD && $past(state) != PH_LOAD) |-> ($past(state) == PH_IDLE && $past(req_valid)));
  // R4: the pin is only released after a driven-low gap
  a_r4_release_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_oe) |-> ($past(state) == PH_GAP));
  // R7: the result strobe lasts one cycle
  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
  // R8: no restart while a transaction is running
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) != PH_IDLE && state == PH_LOAD) |-> ($past(state) == PH_LOAD));
  // R9: result register moves only with the strobe
  a_r9_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(word_data));
endmodule

// File: tb/test_pin_word_sequencer.sv
module test_pin_word_sequencer;
  localparam int W  = 8;
  localparam int LD = 40;
  localparam int SH = 12;
  localparam int WN = 3;
  localparam int GP = 3;
  localparam int LOAD_THR = 30;
  localparam int CLK_THR  = 10;
  localparam int LAT = LD + GP + W * (WN + 2 * GP + SH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready, pin_oe, pin_out, busy, word_valid;
  logic [W-1:0] word_data;
  logic pin;

  always #10 clk = ~clk;

  // remote register model: decodes high-pulse widths
  logic [W-1:0] rem_word = '0;
  logic [W-1:0] rem_sreg = '0;
  int hi_len = 0;
  int rem_loads = 0;
  int rem_shifts = 0;

  assign pin = pin_oe ? pin_out : rem_sreg[W-1];

  pin_word_sequencer #(.DATA_W(W), .LOAD_CYC(LD), .SHIFT_CYC(SH),
                       .WIN_CYC(WN), .GAP_CYC(GP)) i_pin_word_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .pin_in(pin), .pin_oe(pin_oe), .pin_out(pin_out), .busy(busy),
    .word_valid(word_valid), .word_data(word_data)
  );

  always @(posedge clk) begin
    if (pin) hi_len <= hi_len + 1;
    else begin
      if (hi_len >= LOAD_THR) begin rem_sreg <= rem_word; rem_loads <= rem_loads + 1; end
      else if (hi_len >= CLK_THR) begin rem_sreg <= rem_sreg << 1; rem_shifts <= rem_shifts + 1; end
      hi_len <= 0;
    end
  end

  // pin run monitor: 0 low, 1 high, 2 released
  int cur_code = 0, run_len = 0, from_nonlow = 0;
  int n_load = 0, n_shift = 0, n_win = 0, n_gap = 0, n_bad = 0;
  always @(negedge clk) begin
    int code;
    code = !pin_oe ? 2 : (pin_out ? 1 : 0);
    if (code == cur_code) run_len = run_len + 1;
    else begin
      if (cur_code == 1) begin
        if (run_len == LD) n_load++; else if (run_len == SH) n_shift++; else n_bad++;
      end else if (cur_code == 2) begin
        if (run_len == WN) n_win++; else n_bad++;
      end else if (from_nonlow != 0) begin
        if (run_len == GP) n_gap++; else if (run_len < GP) n_bad++;
      end
      from_nonlow = (cur_code != 0) ? 1 : 0;
      cur_code = code;
      run_len = 1;
    end
  end

  int checks = 0, fails = 0;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_word(input logic [W-1:0] w, input bit poke);
    int n;
    rem_word = w;
    @(negedge clk);
    rem_loads = 0; rem_shifts = 0;
    n_load = 0; n_shift = 0; n_win = 0; n_gap = 0; n_bad = 0;
    check("R1 ready before request", req_ready, 1);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (poke && n == 60) begin
        req_valid = 1'b1;
        check("R8 ready low while busy", req_ready, 0);
      end
      if (poke && n == 66) req_valid = 1'b0;
      if (word_valid) break;
      if (n > 4000) begin
        check("watchdog", n, LAT);
        return;
      end
    end
    check("R7 strobe latency", n, LAT);
    check("R6 word recovered", word_data, w);
    check("R2 load pulses", n_load, 1);
    check("R3 shift pulses", n_shift, W);
    check("R4 read windows", n_win, W);
    check("R5 gaps", n_gap, 2 * W);
    check("R5 malformed runs", n_bad, 0);
    check("R3 remote shifts", rem_shifts, W);
    @(negedge clk);
    check("R7 strobe one cycle", word_valid, 0);
    if (poke) begin
      repeat (LD + 10) @(negedge clk);
      check("R8 no late load", rem_loads, 1);
      check("R8 idle pin", {pin_oe, pin_out}, 2'b10);
      check("R9 data held", word_data, w);
    end
  endtask

  initial begin
    logic [W-1:0] dir [6];
    dir = '{8'h00, 8'hFF, 8'h80, 8'h01, 8'hAA, 8'h55};
    void'($urandom(32'h1234_5EED));
    #5;
    check("R1 pin driven low in reset", {pin_oe, pin_out}, 2'b10);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pin low after reset", {pin_oe, pin_out}, 2'b10);
    check("R1 ready after reset", req_ready, 1);
    check("R1 busy after reset", busy, 0);
    check("R1 no strobe after reset", word_valid, 0);
    foreach (dir[i]) run_word(dir[i], i == 2);
    for (int k = 0; k < 24; k++) run_word(W'($urandom), (k % 4) == 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule